// File: doc/BRIEF.md
# Instruction Pointer Advance Unit

This block owns the instruction pointer of a processor front end and moves it once per cycle. Three kinds of request can move it. A sequential fetch advance adds the byte count of the immediate just consumed. A relative branch carries an 8-, 16- or 32-bit displacement together with its size code. An absolute load replaces the pointer with a new target.

An operand-size mode bit selects how relative and sequential results wrap. In 16-bit mode they are cut to the low 16 bits. In 32-bit mode they wrap modulo 2^32. Absolute loads are not masked. Instead, each load target is compared against the code-segment limit. A target above the limit is refused: the pointer keeps its value, and a one-cycle general-protection fault pulse is raised together with an error code of zero.

All updates are registered. A request presented in one cycle is visible on `ip_out` and `gp_fault` after the next rising clock edge. Reset is synchronous and loads a parameterised reset vector.

Top module: `ip_advance_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `ip_out` becomes RESET_VEC (default 0x0000FFF0) and `gp_fault` becomes 0.
- R2: A sequential request with `seq_len` code 0, 1 or 2 adds 1, 2 or 4 bytes to the pointer. Code 3 leaves the pointer unchanged.
- R3: When `wide_mode` is 0, every sequential or relative result is the 32-bit sum masked to its low 16 bits. When `wide_mode` is 1, the sum wraps modulo 2^32.
- R4: A taken branch with `br_size` 0 adds the sign-extended `br_disp[7:0]` plus 1 to the pointer.
- R5: A taken branch with `br_size` 1 adds the sign-extended `br_disp[15:0]` plus 2. With `br_size` 2 it adds `br_disp` plus 4. `br_size` 3 leaves the pointer unchanged.
- R6: A branch with `br_taken` 0 adds only the displacement field length: 1, 2 or 4 bytes for `br_size` 0, 1 or 2.
- R7: A load whose target is at most `cs_limit` (unsigned, equality included) sets the pointer to the target unmasked in either mode, with no fault.
- R8: A load whose target exceeds `cs_limit` leaves the pointer unchanged. In the following cycle it raises `gp_fault` for exactly one cycle, with `gp_err_code` equal to 0.
- R9: Sequential and relative updates never raise `gp_fault`, even when the result passes `cs_limit`.
- R10: When requests coincide, a load wins over a branch, and a branch wins over a sequential advance.
- R11: With no request active, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| cs_limit | input | ADDR_W | Code-segment limit for absolute loads |
| seq_valid | input | 1 | Sequential advance request |
| seq_len | input | 2 | Advance code: 0=1, 1=2, 2=4 bytes, 3=none |
| br_valid | input | 1 | Relative branch request |
| br_taken | input | 1 | Branch taken flag |
| br_size | input | 2 | Displacement size: 0=8, 1=16, 2=32 bits, 3=none |
| br_disp | input | ADDR_W | Displacement, low bits used per size |
| ld_valid | input | 1 | Absolute load request |
| ld_target | input | ADDR_W | Absolute load target |
| ip_out | output | ADDR_W | Current instruction pointer |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_err_code | output | 16 | Fault error code, always zero |

## Verification
The pointer register feeds back into every later update. A wrong value, a missed 16-bit mask or a lost sign extension therefore shows on `ip_out` one edge after the request, and it stays visible in every later vector until the next load. A fault decision taken on the wrong side of the limit shows in the same cycle pair, in two ways: as a missing or extra `gp_fault` pulse, and as a pointer that moved when it should have held. The sweeps cover every 8-bit displacement and a dense spread of 16-bit ones in both modes, starting from bases that straddle the 16-bit wrap point, so that carry and sign errors cannot hide.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

   typedef enum logic [1:0] {
      DSZ_BYTE  = 2'd0,
      DSZ_WORD  = 2'd1,
      DSZ_DWORD = 2'd2,
      DSZ_NONE  = 2'd3
   } disp_size_e;

   localparam int unsigned ERR_CODE_W = 16;

   // Number of bytes the size code covers; zero for the unused code.
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         2'd2:    size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/ipa_step_gen.sv
// Works out the signed delta for a sequential or relative update.
module ipa_step_gen
   import ipa_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              seq_valid,
   input  logic [1:0]        seq_len,
   input  logic              br_valid,
   input  logic              br_taken,
   input  logic [1:0]        br_size,
   input  logic [ADDR_W-1:0] br_disp,
   output logic              step_valid,
   output logic [ADDR_W-1:0] step_delta
);

   localparam int unsigned EXT8  = ADDR_W - 8;
   localparam int unsigned EXT16 = ADDR_W - 16;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] field_len;
   logic [ADDR_W-1:0] seq_amt;
   logic              br_ok;
   logic              seq_ok;

   generate
      if (ADDR_W < 32) begin : g_width_chk
         $error("ipa_step_gen: ADDR_W must be at least 32");
      end
   endgenerate

   always_comb begin
      case (disp_size_e'(br_size))
         DSZ_BYTE:  disp_ext = {{EXT8{br_disp[7]}}, br_disp[7:0]};
         DSZ_WORD:  disp_ext = {{EXT16{br_disp[15]}}, br_disp[15:0]};
         DSZ_DWORD: disp_ext = br_disp;
         default:   disp_ext = '0;
      endcase
   end

   assign field_len = ADDR_W'(size_bytes(br_size));
   assign seq_amt   = ADDR_W'(size_bytes(seq_len));
   assign br_ok     = (br_size != DSZ_NONE);
   assign seq_ok    = (seq_len != 2'd3);

   always_comb begin
      step_valid = 1'b0;
      step_delta = '0;
      if (br_valid) begin
         step_valid = br_ok;
         step_delta = br_taken ? (disp_ext + field_len) : field_len;
      end else if (seq_valid) begin
         step_valid = seq_ok;
         step_delta = seq_amt;
      end
   end

endmodule

// File: rtl/ipa_wrap_mask.sv
// Narrow-mode truncation of a computed pointer.
module ipa_wrap_mask #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned NARROW_W = 16
) (
   input  logic              narrow,
   input  logic [ADDR_W-1:0] value_in,
   output logic [ADDR_W-1:0] value_out
);

   localparam int unsigned PAD_W = ADDR_W - NARROW_W;

   generate
      if (NARROW_W > ADDR_W || NARROW_W == 0) begin : g_bad_narrow
         $error("ipa_wrap_mask: NARROW_W out of range");
      end else if (NARROW_W == ADDR_W) begin : g_passthru
         assign value_out = value_in;
      end else begin : g_masked
         assign value_out = narrow ? {{PAD_W{1'b0}}, value_in[NARROW_W-1:0]}
                                   : value_in;
      end
   endgenerate

endmodule

// File: rtl/ipa_limit_cmp.sv
// Unsigned limit comparison for absolute loads.
module ipa_limit_cmp #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] target,
   input  logic [ADDR_W-1:0] limit,
   output logic              over
);

   assign over = (target > limit);

endmodule

// File: rtl/ip_advance_unit.sv
module ip_advance_unit
   import ipa_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NARROW_W  = 16,
   parameter logic [31:0] RESET_VEC = 32'h0000_FFF0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wide_mode,
   input  logic [ADDR_W-1:0] cs_limit,
   input  logic              seq_valid,
   input  logic [1:0]        seq_len,
   input  logic              br_valid,
   input  logic              br_taken,
   input  logic [1:0]        br_size,
   input  logic [ADDR_W-1:0] br_disp,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_target,
   output logic [ADDR_W-1:0] ip_out,
   output logic              gp_fault,
   output logic [15:0]       gp_err_code
);

   logic [ADDR_W-1:0] ip_q;
   logic              fault_q;
   logic              step_valid;
   logic [ADDR_W-1:0] step_delta;
   logic [ADDR_W-1:0] raw_sum;
   logic [ADDR_W-1:0] wrapped;
   logic              ld_over;

   ipa_step_gen #(.ADDR_W(ADDR_W)) step_i (
      .seq_valid (seq_valid),
      .seq_len   (seq_len),
      .br_valid  (br_valid),
      .br_taken  (br_taken),
      .br_size   (br_size),
      .br_disp   (br_disp),
      .step_valid(step_valid),
      .step_delta(step_delta)
   );

   assign raw_sum = ip_q + step_delta;

   ipa_wrap_mask #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) wrap_i (
      .narrow   (~wide_mode),
      .value_in (raw_sum),
      .value_out(wrapped)
   );

   ipa_limit_cmp #(.ADDR_W(ADDR_W)) lim_i (
      .target(ld_target),
      .limit (cs_limit),
      .over  (ld_over)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ip_q    <= ADDR_W'(RESET_VEC);
         fault_q <= 1'b0;
      end else begin
         fault_q <= ld_valid & ld_over;
         if (ld_valid) begin
            if (!ld_over) ip_q <= ld_target;
         end else if (step_valid) begin
            ip_q <= wrapped;
         end
      end
   end

   assign ip_out      = ip_q;
   assign gp_fault    = fault_q;
   assign gp_err_code = '0;

endmodule

// File: rtl/ipa_checker.sv
module ipa_checker #(
   parameter int unsigned ADDR_W    = 32,
   parameter logic [31:0] RESET_VEC = 32'h0000_FFF0
) (
   input logic              clk,
   input logic              rst,
   input logic              wide_mode,
   input logic [ADDR_W-1:0] cs_limit,
   input logic              seq_valid,
   input logic [1:0]        seq_len,
   input logic              br_valid,
   input logic [1:0]        br_size,
   input logic              ld_valid,
   input logic [ADDR_W-1:0] ld_target,
   input logic [ADDR_W-1:0] ip_out,
   input logic              gp_fault
);

   logic moves_rel;
   assign moves_rel = !ld_valid &&
                      ((br_valid && br_size != 2'd3) ||
                       (!br_valid && seq_valid && seq_len != 2'd3));

   p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> ip_out == ADDR_W'(RESET_VEC));

   p_narrow_mask_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(moves_rel && !wide_mode)) |-> ip_out[ADDR_W-1:16] == '0);

   p_load_ok_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ld_valid && ld_target <= cs_limit)) |-> ip_out == $past(ld_target));

   p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && gp_fault) |-> ip_out == $past(ip_out));

   p_fault_cause_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && gp_fault) |-> $past(ld_valid && ld_target > cs_limit));

   p_no_rel_fault_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ld_valid)) |-> !gp_fault);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(!ld_valid && !br_valid && !seq_valid)) |-> $stable(ip_out));

endmodule

bind ip_advance_unit ipa_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .wide_mode(wide_mode),
   .cs_limit (cs_limit),
   .seq_valid(seq_valid),
   .seq_len  (seq_len),
   .br_valid (br_valid),
   .br_size  (br_size),
   .ld_valid (ld_valid),
   .ld_target(ld_target),
   .ip_out   (ip_out),
   .gp_fault (gp_fault)
);

// File: tb/ip_advance_unit_tb.sv
module ip_advance_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RVEC = 32'h0000_FFF0;

   logic        clk = 1'b0;
   logic        rst;
   logic        wide_mode;
   logic [31:0] cs_limit;
   logic        seq_valid;
   logic [1:0]  seq_len;
   logic        br_valid;
   logic        br_taken;
   logic [1:0]  br_size;
   logic [31:0] br_disp;
   logic        ld_valid;
   logic [31:0] ld_target;
   logic [31:0] ip_out;
   logic        gp_fault;
   logic [15:0] gp_err_code;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;
   logic [31:0] model_ip;

   always #(CLK_PERIOD/2) clk = ~clk;

   ip_advance_unit dut_i (
      .clk(clk), .rst(rst), .wide_mode(wide_mode), .cs_limit(cs_limit),
      .seq_valid(seq_valid), .seq_len(seq_len), .br_valid(br_valid),
      .br_taken(br_taken), .br_size(br_size), .br_disp(br_disp),
      .ld_valid(ld_valid), .ld_target(ld_target), .ip_out(ip_out),
      .gp_fault(gp_fault), .gp_err_code(gp_err_code)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      seq_valid = 0; seq_len = 0; br_valid = 0; br_taken = 0;
      br_size = 0; br_disp = 0; ld_valid = 0; ld_target = 0;
   endtask

   function automatic logic [31:0] fold(input logic [31:0] v);
      return wide_mode ? v : (v & 32'h0000_FFFF);
   endfunction

   // Apply inputs already set, clock once, sample at following negedge.
   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_load(input logic [31:0] t);
      ld_valid = 1; ld_target = t;
      cycle();
      if (t <= cs_limit) model_ip = t;
   endtask

   task automatic do_branch(input string req, input logic [1:0] sz, input bit tk,
                            input logic [31:0] d);
      logic [31:0] ext;
      logic [31:0] flen;
      br_valid = 1; br_size = sz; br_taken = tk; br_disp = d;
      case (sz)
         2'd0: begin ext = {{24{d[7]}}, d[7:0]}; flen = 1; end
         2'd1: begin ext = {{16{d[15]}}, d[15:0]}; flen = 2; end
         2'd2: begin ext = d; flen = 4; end
         default: begin ext = 0; flen = 0; end
      endcase
      cycle();
      if (sz != 2'd3) model_ip = fold(model_ip + (tk ? ext + flen : flen));
      check(req, ip_out, model_ip);
      check({req, " nofault R9"}, {31'd0, gp_fault}, 32'd0);
   endtask

   task automatic do_seq(input logic [1:0] code);
      seq_valid = 1; seq_len = code;
      cycle();
      case (code)
         2'd0: model_ip = fold(model_ip + 1);
         2'd1: model_ip = fold(model_ip + 2);
         2'd2: model_ip = fold(model_ip + 4);
         default: ;
      endcase
      check("R2 seq", ip_out, model_ip);
   endtask

   initial begin
      idle_inputs();
      wide_mode = 1; cs_limit = 32'hFFFF_FFFF;
      rst = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset ip", ip_out, RVEC);
      check("R1 reset fault", {31'd0, gp_fault}, 0);
      rst = 0;
      model_ip = RVEC;

      // R11 idle
      cycle(); cycle();
      check("R11 idle hold", ip_out, model_ip);

      for (int m = 0; m < 2; m++) begin
         wide_mode = m[0];
         // R2 sequential, every code
         for (int c = 0; c < 4; c++) begin
            do_load(wide_mode ? 32'h7FFF_FFFE : 32'h0000_FFFE);
            do_seq(c[1:0]);
            do_seq(c[1:0]);
         end
         // R4 every 8-bit displacement, taken, across wrap base; R3 masks
         for (int d = 0; d < 256; d++) begin
            do_load(wide_mode ? 32'hFFFF_FFC0 : 32'h0000_FFC0);
            do_branch("R4 short R3", 2'd0, 1'b1, 32'(d));
         end
         // R5 16-bit spread
         for (int d = 0; d < 65536; d += 257) begin
            do_load(wide_mode ? 32'h0000_8000 : 32'h0000_FF00);
            do_branch("R5 near16 R3", 2'd1, 1'b1, 32'(d) | 32'hABCD_0000);
         end
         // R5 32-bit values
         for (int k = 0; k < 32; k++) begin
            do_load(32'h0000_1000);
            do_branch("R5 near32 R3", 2'd2, 1'b1, 32'h1 << k);
            do_branch("R5 near32 neg", 2'd2, 1'b1, 32'hFFFF_FF00 - 32'(k));
         end
         do_branch("R5 size3 hold", 2'd3, 1'b1, 32'h55);
         // R6 not taken each size
         for (int s = 0; s < 4; s++) begin
            do_load(wide_mode ? 32'hFFFF_FFFE : 32'h0000_FFFE);
            do_branch("R6 not taken", s[1:0], 1'b0, 32'h7F7F_7F7F);
         end
      end

      // R7 loads around limit, unmasked in narrow mode
      wide_mode = 0; cs_limit = 32'h0012_3456;
      do_load(32'h0012_3455); check("R7 below limit", ip_out, 32'h0012_3455);
      check("R7 no fault", {31'd0, gp_fault}, 0);
      do_load(32'h0012_3456); check("R7 at limit", ip_out, 32'h0012_3456);
      check("R7 no fault eq", {31'd0, gp_fault}, 0);
      // R9 relative past limit: no fault
      do_branch("R9 past limit", 2'd2, 1'b1, 32'h0100_0000);
      wide_mode = 1;
      do_branch("R9 past limit wide", 2'd2, 1'b1, 32'h0100_0000);
      // R8 over limit
      do_load(32'h0012_3457);
      check("R8 hold", ip_out, model_ip);
      check("R8 fault", {31'd0, gp_fault}, 1);
      check("R8 err code", {16'd0, gp_err_code}, 0);
      cycle();
      check("R8 pulse ends", {31'd0, gp_fault}, 0);
      do_load(32'hFFFF_FFFF);
      check("R8 hold max", ip_out, model_ip);
      check("R8 fault max", {31'd0, gp_fault}, 1);

      // R10 priority
      cs_limit = 32'hFFFF_FFFF;
      do_load(32'h0000_2000);
      ld_valid = 1; ld_target = 32'h0000_3000;
      br_valid = 1; br_size = 0; br_taken = 1; br_disp = 8'h10;
      seq_valid = 1; seq_len = 2;
      cycle(); model_ip = 32'h0000_3000;
      check("R10 load wins", ip_out, model_ip);
      br_valid = 1; br_size = 0; br_taken = 1; br_disp = 8'h10;
      seq_valid = 1; seq_len = 2;
      cycle(); model_ip = model_ip + 32'h11;
      check("R10 branch wins", ip_out, model_ip);
      cs_limit = 32'h0000_0100;
      ld_valid = 1; ld_target = 32'h0000_0200; seq_valid = 1; seq_len = 0;
      cycle();
      check("R10 faulting load blocks seq", ip_out, model_ip);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule